// File: doc/BRIEF.md
# Forced Branch-and-Store Interrupt Sequencer

This block performs the memory traffic that carries the processor into an interrupt routine and back out of it. When the priority controller grants a level, the sequencer forms that level's vector word address and reads the routine's first-word address from it. It then stores the instruction address that was current at the grant into that first word, and hands the instruction address register the first-word address plus one, so execution resumes at the routine's second word.

Leaving a routine is the reverse path. The return instruction supplies the routine's first-word address and level. The sequencer reads the saved address from that word, loads it into the instruction address register, and raises a one-cycle request to clear the level in the priority controller. Every access goes through a single-port word memory with a request/ready handshake, so wait states of any length are tolerated.

Top module: `irq_bsi_seq`

## Requirements
- R1: A grant of level n (0 to 5) in idle issues a read (mem_we_o low) at address 8 + n in the next cycle.
- R2: The word returned by the vector read is the effective address. The next access is a write to that address whose data is the saved instruction address.
- R3: One cycle after the write is accepted, iar_load_o and done_o pulse high for one cycle, with iar_val_o equal to the effective address plus 1. For a vector holding 600 and an instruction address of 502, word 600 receives 502 and iar_val_o is 601.
- R4: The effective-address increment wraps modulo 2^16, so an effective address of 0xFFFF loads 0x0000.
- R5: A return request in idle reads ret_addr_i and loads the word read into the instruction address register. It pulses lvl_clr_o together with done_o and gives lvl_clr_id_o = ret_lvl_i.
- R6: While a request is waiting for mem_ready_i, the address, write enable and write data stay unchanged. Each access takes one cycle more than its wait states.
- R7: A grant or return that arrives while busy_o is high is ignored. It starts no access after the current sequence ends.
- R8: A grant with a level of 6 or higher is ignored and leaves busy_o and mem_req_o low.
- R9: done_o lasts one cycle and is followed by idle. lvl_clr_o stays low on entry sequences.
- R10: The saved instruction address is the value of iar_i in the grant cycle. Later changes to iar_i have no effect.
- R11: If a valid grant and a return arrive in the same idle cycle, the grant wins and an entry sequence runs.
- R12: After reset, mem_req_o, busy_o, done_o, iar_load_o and lvl_clr_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Level granted by the priority controller |
| grant_lvl_i | input | 3 | Granted level number |
| ret_i | input | 1 | Return-from-routine request |
| ret_addr_i | input | 16 | Routine first-word address for the return |
| ret_lvl_i | input | 3 | Level being left |
| iar_i | input | 16 | Current instruction address |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | 16 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| iar_load_o | output | 1 | Load strobe for the instruction address register |
| iar_val_o | output | 16 | Value to load |
| done_o | output | 1 | Sequence complete |
| lvl_clr_o | output | 1 | Clear the level in the priority controller |
| lvl_clr_id_o | output | 3 | Level to clear |
| busy_o | output | 1 | Sequence in progress |

## Verification
The assertions assume the memory raises mem_ready_i only while mem_req_o is high, and returns the read data in the same cycle as ready. They also assume that grant_i and ret_i are single-cycle pulses from the controller. The bench's memory model raises ready only against a pending request, after a programmable number of wait states. Grants and returns are driven for exactly one cycle at the falling edge. Stray grants and returns are issued only while the block is busy, or with a level that is out of range.

// File: rtl/irq_bsi_pkg.sv
package irq_bsi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_VEC,
    ST_WRITE_RET,
    ST_LOAD_IAR,
    ST_RET_READ
  } seq_st_e;
endpackage

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
  parameter int NUM_LVL  = 6,
  parameter int LW       = 3,
  parameter int WW       = 16,
  parameter int VEC_BASE = 8
) (
  input  logic [LW-1:0] lvl_i,
  output logic          valid_o,
  output logic [WW-1:0] vec_addr_o
);
  logic [NUM_LVL-1:0] hit;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign hit[g] = (lvl_i == LW'(g));
  end

  assign valid_o    = |hit;
  assign vec_addr_o = WW'(VEC_BASE) + WW'(lvl_i);
endmodule

// File: rtl/irq_bsi_fsm.sv
module irq_bsi_fsm
  import irq_bsi_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    grant_ok_i,
  input  logic    ret_i,
  input  logic    mem_ready_i,
  output seq_st_e st_o,
  output logic    ret_mode_o
);
  seq_st_e st_q;
  logic    ret_mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ret_mode_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          // grant beats return
          if (grant_ok_i) begin
            st_q       <= ST_READ_VEC;
            ret_mode_q <= 1'b0;
          end else if (ret_i) begin
            st_q       <= ST_RET_READ;
            ret_mode_q <= 1'b1;
          end
        end
        ST_READ_VEC:  if (mem_ready_i) st_q <= ST_WRITE_RET;
        ST_WRITE_RET: if (mem_ready_i) st_q <= ST_LOAD_IAR;
        ST_RET_READ:  if (mem_ready_i) st_q <= ST_LOAD_IAR;
        ST_LOAD_IAR:  st_q <= ST_IDLE;
        default:      st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o       = st_q;
  assign ret_mode_o = ret_mode_q;
endmodule

// File: rtl/irq_bsi_dp.sv
module irq_bsi_dp
  import irq_bsi_pkg::*;
#(
  parameter int LW = 3,
  parameter int WW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  seq_st_e       st_i,
  input  logic          grant_ok_i,
  input  logic          ret_i,
  input  logic [LW-1:0] grant_lvl_i,
  input  logic [LW-1:0] ret_lvl_i,
  input  logic [WW-1:0] ret_addr_i,
  input  logic [WW-1:0] vec_addr_i,
  input  logic [WW-1:0] iar_i,
  input  logic [WW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [WW-1:0] mem_addr_o,
  output logic [WW-1:0] mem_wdata_o,
  output logic [WW-1:0] nxt_o,
  output logic [LW-1:0] lvl_o
);
  logic [LW-1:0] lvl_q;
  logic [WW-1:0] sav_q, ea_q, nxt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      sav_q <= '0;
      ea_q  <= '0;
      nxt_q <= '0;
    end else begin
      unique case (st_i)
        ST_IDLE: begin
          if (grant_ok_i) begin
            lvl_q <= grant_lvl_i;
            sav_q <= iar_i;
            ea_q  <= vec_addr_i;  // addr register first holds the vector slot
          end else if (ret_i) begin
            lvl_q <= ret_lvl_i;
            ea_q  <= ret_addr_i;
          end
        end
        ST_READ_VEC:  if (mem_ready_i) ea_q  <= mem_rdata_i;
        ST_WRITE_RET: if (mem_ready_i) nxt_q <= ea_q + WW'(1);
        ST_RET_READ:  if (mem_ready_i) nxt_q <= mem_rdata_i;
        default: ;
      endcase
    end
  end

  assign mem_req_o   = (st_i == ST_READ_VEC) || (st_i == ST_WRITE_RET) || (st_i == ST_RET_READ);
  assign mem_we_o    = (st_i == ST_WRITE_RET);
  assign mem_addr_o  = ea_q;
  assign mem_wdata_o = mem_we_o ? sav_q : '0;
  assign nxt_o       = nxt_q;
  assign lvl_o       = lvl_q;
endmodule

// File: rtl/irq_bsi_seq.sv
module irq_bsi_seq
  import irq_bsi_pkg::*;
#(
  parameter int NUM_LVL  = 6,
  parameter int WW       = 16,
  parameter int VEC_BASE = 8,
  localparam int LW      = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          grant_i,
  input  logic [LW-1:0] grant_lvl_i,
  input  logic          ret_i,
  input  logic [WW-1:0] ret_addr_i,
  input  logic [LW-1:0] ret_lvl_i,
  input  logic [WW-1:0] iar_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [WW-1:0] mem_addr_o,
  output logic [WW-1:0] mem_wdata_o,
  input  logic [WW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          iar_load_o,
  output logic [WW-1:0] iar_val_o,
  output logic          done_o,
  output logic          lvl_clr_o,
  output logic [LW-1:0] lvl_clr_id_o,
  output logic          busy_o
);
  seq_st_e       st;
  logic          ret_mode, lvl_ok, grant_ok;
  logic [WW-1:0] vec_addr;

  irq_vec_map #(.NUM_LVL(NUM_LVL), .LW(LW), .WW(WW), .VEC_BASE(VEC_BASE)) u_map (
    .lvl_i      (grant_lvl_i),
    .valid_o    (lvl_ok),
    .vec_addr_o (vec_addr)
  );

  assign grant_ok = grant_i && lvl_ok;

  irq_bsi_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .grant_ok_i  (grant_ok),
    .ret_i       (ret_i),
    .mem_ready_i (mem_ready_i),
    .st_o        (st),
    .ret_mode_o  (ret_mode)
  );

  irq_bsi_dp #(.LW(LW), .WW(WW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .st_i        (st),
    .grant_ok_i  (grant_ok),
    .ret_i       (ret_i),
    .grant_lvl_i (grant_lvl_i),
    .ret_lvl_i   (ret_lvl_i),
    .ret_addr_i  (ret_addr_i),
    .vec_addr_i  (vec_addr),
    .iar_i       (iar_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_ready_i (mem_ready_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .nxt_o       (iar_val_o),
    .lvl_o       (lvl_clr_id_o)
  );

  assign done_o     = (st == ST_LOAD_IAR);
  assign iar_load_o = done_o;
  assign lvl_clr_o  = done_o && ret_mode;
  assign busy_o     = (st != ST_IDLE);
endmodule

// File: rtl/irq_bsi_seq_chk.sv
module irq_bsi_seq_chk #(
  parameter int NUM_LVL  = 6,
  parameter int WW       = 16,
  parameter int VEC_BASE = 8,
  parameter int LW       = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          grant_i,
  input logic [LW-1:0] grant_lvl_i,
  input logic          ret_i,
  input logic          busy_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [WW-1:0] mem_addr_o,
  input logic [WW-1:0] mem_wdata_o,
  input logic          mem_ready_i,
  input logic          done_o,
  input logic [WW-1:0] iar_val_o,
  input logic          lvl_clr_o
);
  AST_GRANT_VEC_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && grant_i && (int'(grant_lvl_i) < NUM_LVL)) |=>
      (mem_req_o && !mem_we_o && mem_addr_o == WW'(VEC_BASE) + WW'($past(grant_lvl_i)))); // R1

  AST_WRITE_THEN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ready_i) |=>
      (done_o && iar_val_o == $past(mem_addr_o) + WW'(1))); // R3

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o))); // R6

  AST_BAD_LVL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && grant_i && (int'(grant_lvl_i) >= NUM_LVL) && !ret_i) |=> !busy_o); // R8

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R9

  AST_CLR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_clr_o |-> (done_o && !mem_req_o)); // R5
endmodule

bind irq_bsi_seq irq_bsi_seq_chk #(
  .NUM_LVL(NUM_LVL), .WW(WW), .VEC_BASE(VEC_BASE), .LW(LW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .grant_i     (grant_i),
  .grant_lvl_i (grant_lvl_i),
  .ret_i       (ret_i),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .done_o      (done_o),
  .iar_val_o   (iar_val_o),
  .lvl_clr_o   (lvl_clr_o)
);

// File: tb/irq_bsi_seq_tb.sv
module irq_bsi_seq_tb;
  localparam int WW = 16;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          grant = 1'b0;
  logic [LW-1:0] grant_lvl = '0;
  logic          ret = 1'b0;
  logic [WW-1:0] ret_addr = '0;
  logic [LW-1:0] ret_lvl = '0;
  logic [WW-1:0] iar = '0;
  logic          mem_req, mem_we, mem_ready;
  logic [WW-1:0] mem_addr, mem_wdata, mem_rdata;
  logic          iar_load, done, lvl_clr, busy;
  logic [WW-1:0] iar_val;
  logic [LW-1:0] lvl_clr_id;

  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;
  int wcnt = 0;
  logic [WW-1:0] mem [0:1023];

  always #10ns clk = ~clk;

  irq_bsi_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .grant_i(grant), .grant_lvl_i(grant_lvl),
    .ret_i(ret), .ret_addr_i(ret_addr), .ret_lvl_i(ret_lvl), .iar_i(iar),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
    .iar_load_o(iar_load), .iar_val_o(iar_val), .done_o(done),
    .lvl_clr_o(lvl_clr), .lvl_clr_id_o(lvl_clr_id), .busy_o(busy)
  );

  // memory model with programmable wait states
  assign mem_ready = mem_req && (wcnt == lat);
  assign mem_rdata = mem_ready ? mem[mem_addr[9:0]] : '0;
  always @(posedge clk) begin
    if (mem_req && !mem_ready) wcnt <= wcnt + 1;
    else                       wcnt <= 0;
    if (mem_req && mem_we && mem_ready) mem[mem_addr[9:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wait_done(output int k);
    k = 1;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset();
    chk(!mem_req && !busy && !done && !iar_load && !lvl_clr, "R12 reset outputs",
        int'({mem_req, busy, done, iar_load, lvl_clr}), 0);
  endtask

  // entry: grant, then check vector read, store, IAR load and timing
  task automatic t_entry(input int lv, input logic [WW-1:0] cur, input logic [WW-1:0] ea,
                         input int l, input bit with_ret);
    int k;
    logic [WW-1:0] first_addr, wr_addr, wr_data;
    bit first_we;
    lat = l;
    mem[10'(8 + lv)] = ea;
    mem[ea[9:0]] = 16'h1234;
    @(negedge clk);
    grant = 1'b1; grant_lvl = LW'(lv); iar = cur;
    if (with_ret) begin ret = 1'b1; ret_addr = 16'd900; ret_lvl = 3'd2; end
    @(negedge clk);
    grant = 1'b0; ret = 1'b0; iar = 16'hBEEF;
    first_addr = mem_addr; first_we = mem_we;
    wr_addr = '0; wr_data = '0;
    k = 1;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
      if (mem_req && mem_we) begin wr_addr = mem_addr; wr_data = mem_wdata; end
    end
    chk(first_addr == WW'(8 + lv) && !first_we, with_ret ? "R11 grant wins, vector read" : "R1 vector address",
        int'(first_addr), 8 + lv);
    chk(wr_addr == ea, "R2 store address is effective address", int'(wr_addr), int'(ea));
    chk(wr_data == cur && mem[ea[9:0]] == cur, "R10 saved IAR is grant-cycle value",
        int'(mem[ea[9:0]]), int'(cur));
    chk(iar_load && iar_val == ea + 16'd1, (ea == 16'hFFFF) ? "R4 wrap" : "R3 IAR = EA+1",
        int'(iar_val), int'(ea + 16'd1));
    chk(k == 2 * (l + 1) + 1, "R6 cycles with wait states", k, 2 * (l + 1) + 1);
    chk(!lvl_clr, "R9 no level clear on entry", int'(lvl_clr), 0);
    @(negedge clk);
    chk(!done && !busy && !iar_load, "R9 done is one cycle", int'({done, busy}), 0);
  endtask

  task automatic t_return(input logic [WW-1:0] fw, input logic [WW-1:0] saved, input int lv, input int l);
    int k;
    logic [WW-1:0] a;
    bit w;
    lat = l;
    mem[fw[9:0]] = saved;
    @(negedge clk);
    ret = 1'b1; ret_addr = fw; ret_lvl = LW'(lv);
    @(negedge clk);
    ret = 1'b0; ret_addr = 16'd0;
    a = mem_addr; w = mem_we;
    wait_done(k);
    chk(a == fw && !w, "R5 return reads first word", int'(a), int'(fw));
    chk(iar_load && iar_val == saved, "R5 return IAR value", int'(iar_val), int'(saved));
    chk(lvl_clr && lvl_clr_id == LW'(lv), "R5 level clear", int'(lvl_clr_id), lv);
    chk(k == (l + 1) + 1, "R6 return cycles", k, l + 2);
  endtask

  task automatic t_busy_grant();
    int k, dones, reqs;
    lat = 2;
    mem[10'd8] = 16'd700;
    @(negedge clk);
    grant = 1'b1; grant_lvl = 3'd0; iar = 16'd40;
    @(negedge clk);
    grant = 1'b0;
    @(negedge clk);
    grant = 1'b1; grant_lvl = 3'd3; ret = 1'b1; ret_addr = 16'd50;
    @(negedge clk);
    grant = 1'b0; ret = 1'b0;
    dones = 0; reqs = 0;
    for (int i = 0; i < 16; i++) begin
      if (done) dones++;
      if (done) k = i;
      @(negedge clk);
      if (dones > 0 && mem_req) reqs++;
    end
    chk(dones == 1, "R7 single sequence", dones, 1);
    chk(reqs == 0 && !busy, "R7 stray grant ignored", reqs, 0);
  endtask

  task automatic t_bad_lvl(input int lv);
    int reqs;
    reqs = 0;
    @(negedge clk);
    grant = 1'b1; grant_lvl = LW'(lv);
    @(negedge clk);
    grant = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (mem_req || busy) reqs++;
      @(negedge clk);
    end
    chk(reqs == 0, "R8 out-of-range level ignored", reqs, 0);
  endtask

  initial begin
    #(20ns * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_entry(0, 16'd502, 16'd600, 0, 1'b0);   // worked case: R3
    chk(mem[600] == 16'd502, "R3 word 600 holds 502", int'(mem[600]), 502);
    for (int lv = 1; lv < 6; lv++) t_entry(lv, 16'(100 + lv), 16'(200 + 16 * lv), lv % 3, 1'b0);
    t_entry(4, 16'd77, 16'hFFFF, 1, 1'b0);   // R4
    t_return(16'd600, 16'd502, 0, 0);
    t_return(16'd232, 16'd999, 5, 3);
    t_entry(2, 16'd321, 16'd400, 0, 1'b1);   // R11
    t_busy_grant();
    t_bad_lvl(6);
    t_bad_lvl(7);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule